// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the host-facing register file of a three-channel interval timer. A byte-wide bus with a 2-bit address reaches three channel data ports and one control port. Through the control port the host either programs a channel (its access type and counting mode) or asks it to take a snapshot of its running count. Through a data port the host writes a 16-bit initial count, and reads back either the snapshot or the running count, one byte per access.

Each channel gets from this block its mode, its initial count with a one-cycle load strobe, and a one-cycle snapshot request. Each channel also returns its running count to this block. Every channel keeps its own byte-order state for writes and for reads, so an access to one channel never disturbs a transfer in progress on another. The counters that decrement are not part of this block.

Top module: `tmr_host_regs`

## Requirements
- R1: After reset every channel has mode 0, count 0 and access type 3 (two bytes), no load strobe or snapshot request is asserted, and `rdata` is 0.
- R2: Address 0, 1 and 2 reach the data port of channel 0, 1 and 2; address 3 is the control port. A control word whose channel field (bits 7:6) is 3 changes no channel state and raises no strobe.
- R3: A control word with access field (bits 5:4) not 0 sets the addressed channel's access type to that field and its mode to bits 3:1. Bit 0 is ignored, and no other channel's mode changes.
- R4: With access type 3, the first data write stores the low byte and the second supplies the high byte. `ch_load` for that channel is high for exactly the cycle after the high-byte write, with `ch_count` then holding {high, low}. A low-byte write leaves `ch_load` low and `ch_count` unchanged.
- R5: With access type 1, every data write loads {0x00, byte}. With access type 2, every data write loads {byte, 0x00}. In both cases `ch_load` pulses the cycle after each write. Reads then return only the low byte or only the high byte, respectively.
- R6: A control word with access field 0 captures the channel's running count into a snapshot and pulses that channel's `ch_latch` the cycle after. It leaves the mode and access type unchanged.
- R7: While a snapshot is held, data reads return its bytes (low byte first under access type 3), whatever the running count does. The snapshot is released when its last byte is read.
- R8: A snapshot command to a channel that already holds a snapshot is ignored: no `ch_latch` pulse, and the held value is kept.
- R9: With no snapshot held, data reads return the running count using the same byte sequencing.
- R10: Programming a channel resets its write and read byte order to expect the low byte, and discards any held snapshot.
- R11: `rdata` updates on the clock edge that samples a read. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Port address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |
| live_cnt | input | 48 | Running counts from the channels, 16 bits each, channel 0 lowest |
| ch_mode | output | 9 | Mode per channel, 3 bits each |
| ch_count | output | 48 | Initial count per channel, 16 bits each |
| ch_load | output | 3 | Load strobe per channel |
| ch_latch | output | 3 | Snapshot request per channel |

## Verification
The bench builds the block with its default parameters: three channels, 16-bit counts and 8-bit bus bytes. With these values, every channel, every access type and all six modes can be swept. A range of count values is written to each channel in turn, and the untouched channels are checked on every write. The bench also drives distinct running counts per channel, so snapshot hold, release, duplicate commands and reprogramming can each be compared against arithmetic expectations.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH   = 3;
    localparam int CNT_W = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 3;
    localparam int ADDR_W = $clog2(NCH + 1);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NCH);

    typedef enum logic [1:0] {
        ACC_SNAP = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    typedef struct packed {
        logic [1:0]        sel;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              spare;
    } ctl_word_t;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    function automatic ctl_word_t unpack_ctl(input byte_t b);
        return ctl_word_t'(b);
    endfunction

    function automatic byte_t pick_byte(input cnt_t v, input logic hi);
        return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
    import tmr_pkg::*;
(
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  byte_t                 wdata,
    output logic [NCH-1:0]        prog,
    output logic [NCH-1:0]        snap,
    output logic [NCH-1:0]        dwr,
    output logic [NCH-1:0]        drd,
    output acc_e                  acc,
    output logic [MODE_W-1:0]     mode
);
    ctl_word_t cw;
    logic      ctl_wr;

    always_comb begin
        cw     = unpack_ctl(wdata);
        ctl_wr = wr_en && (addr == CTL_ADDR);
        acc    = cw.acc;
        mode   = cw.mode;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        always_comb begin
            prog[i] = ctl_wr && (cw.sel == 2'(i)) && (cw.acc != ACC_SNAP);
            snap[i] = ctl_wr && (cw.sel == 2'(i)) && (cw.acc == ACC_SNAP);
            dwr[i]  = wr_en && (addr == ADDR_W'(i));
            drd[i]  = rd_en && (addr == ADDR_W'(i));
        end
    end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_i,
    input  logic              snap_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  acc_e              acc_i,
    input  logic [MODE_W-1:0] mode_i,
    input  byte_t             wdata_i,
    input  cnt_t              live_i,
    output logic [MODE_W-1:0] mode_o,
    output cnt_t              cnt_o,
    output logic              load_o,
    output logic              latch_o,
    output byte_t             rbyte_o
);
    acc_e  acc_q;
    logic  wr_hi_q, rd_hi_q, held_q;
    byte_t lo_q;
    cnt_t  snap_q;
    cnt_t  src;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o  <= '0;
            acc_q   <= ACC_WORD;
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
            held_q  <= 1'b0;
            lo_q    <= '0;
            snap_q  <= '0;
            cnt_o   <= '0;
            load_o  <= 1'b0;
            latch_o <= 1'b0;
        end else begin
            load_o  <= 1'b0;
            latch_o <= 1'b0;
            if (prog_i) begin
                mode_o  <= mode_i;
                acc_q   <= acc_i;
                wr_hi_q <= 1'b0;
                rd_hi_q <= 1'b0;
                held_q  <= 1'b0;
            end else if (snap_i && !held_q) begin
                held_q  <= 1'b1;
                snap_q  <= live_i;
                latch_o <= 1'b1;
            end
            if (wr_i) begin
                unique case (acc_q)
                    ACC_LO: begin
                        cnt_o  <= {byte_t'(0), wdata_i};
                        load_o <= 1'b1;
                    end
                    ACC_HI: begin
                        cnt_o  <= {wdata_i, byte_t'(0)};
                        load_o <= 1'b1;
                    end
                    default: begin
                        if (wr_hi_q) begin
                            cnt_o  <= {wdata_i, lo_q};
                            load_o <= 1'b1;
                        end else begin
                            lo_q <= wdata_i;
                        end
                        wr_hi_q <= !wr_hi_q;
                    end
                endcase
            end
            if (rd_i) begin
                if (acc_q == ACC_WORD) begin
                    rd_hi_q <= !rd_hi_q;
                    if (rd_hi_q) held_q <= 1'b0;
                end else begin
                    held_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        src = held_q ? snap_q : live_i;
        unique case (acc_q)
            ACC_LO:  rbyte_o = pick_byte(src, 1'b0);
            ACC_HI:  rbyte_o = pick_byte(src, 1'b1);
            default: rbyte_o = pick_byte(src, rd_hi_q);
        endcase
    end
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import tmr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NCH*BYTE_W-1:0]  bytes_i,
    output byte_t                  rdata
);
    byte_t sel_byte;

    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NCH; i++)
            if (addr == ADDR_W'(i)) sel_byte = bytes_i[i*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= sel_byte;
    end
endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
    import tmr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [1:0]              addr,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    input  logic [NCH*CNT_W-1:0]    live_cnt,
    output logic [NCH*MODE_W-1:0]   ch_mode,
    output logic [NCH*CNT_W-1:0]    ch_count,
    output logic [NCH-1:0]          ch_load,
    output logic [NCH-1:0]          ch_latch
);
    logic [NCH-1:0]          prog, snap, dwr, drd;
    acc_e                    acc;
    logic [MODE_W-1:0]       mode;
    logic [NCH*BYTE_W-1:0]   rbytes;

    tmr_ctl_decode u_dec (
        .wr_en (wr_en), .rd_en (rd_en), .addr (addr), .wdata (wdata),
        .prog (prog), .snap (snap), .dwr (dwr), .drd (drd),
        .acc (acc), .mode (mode)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_chan_regs u_ch (
            .clk     (clk),
            .rst     (rst),
            .prog_i  (prog[i]),
            .snap_i  (snap[i]),
            .wr_i    (dwr[i]),
            .rd_i    (drd[i]),
            .acc_i   (acc),
            .mode_i  (mode),
            .wdata_i (wdata),
            .live_i  (live_cnt[i*CNT_W +: CNT_W]),
            .mode_o  (ch_mode[i*MODE_W +: MODE_W]),
            .cnt_o   (ch_count[i*CNT_W +: CNT_W]),
            .load_o  (ch_load[i]),
            .latch_o (ch_latch[i]),
            .rbyte_o (rbytes[i*BYTE_W +: BYTE_W])
        );
    end

    tmr_read_mux u_rd (
        .clk (clk), .rst (rst), .rd_en (rd_en), .addr (addr),
        .bytes_i (rbytes), .rdata (rdata)
    );
endmodule

// File: rtl/tmr_host_regs_chk.sv
module tmr_host_regs_chk
    import tmr_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [1:0]            addr,
    input logic [7:0]            wdata,
    input logic [7:0]            rdata,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic [NCH*CNT_W-1:0]  ch_count,
    input logic [NCH-1:0]        ch_load,
    input logic [NCH-1:0]        ch_latch
);
    // R11: control reads return zero
    a_r11_ctl_read_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_en && addr == 2'd3)) |-> (rdata == 8'h00));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R4/R5: a load strobe follows a data write to that channel
        a_r4_load_after_write: assert property (@(posedge clk) disable iff (rst)
            ch_load[i] |-> (!$past(rst) && $past(wr_en && addr == 2'(i))));
        // R4: the initial count moves only together with its strobe
        a_r4_count_with_strobe: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !ch_load[i]) |-> $stable(ch_count[i*CNT_W +: CNT_W]));
        // R6: a snapshot request follows a snapshot command for that channel
        a_r6_latch_after_cmd: assert property (@(posedge clk) disable iff (rst)
            ch_latch[i] |-> (!$past(rst) && $past(wr_en && addr == 2'd3 &&
                wdata[7:6] == 2'(i) && wdata[5:4] == 2'd0)));
        // R3: mode changes only on a programming word for that channel
        a_r3_mode_only_on_prog: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(wr_en && addr == 2'd3 && wdata[7:6] == 2'(i) &&
                wdata[5:4] != 2'd0)) |-> $stable(ch_mode[i*MODE_W +: MODE_W]));
    end
endmodule

bind tmr_host_regs tmr_host_regs_chk u_chk (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
    .wdata (wdata), .rdata (rdata), .ch_mode (ch_mode), .ch_count (ch_count),
    .ch_load (ch_load), .ch_latch (ch_latch)
);

// File: tb/sim_tmr_host_regs.sv
module sim_tmr_host_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] live_cnt = '0;
    logic [8:0]  ch_mode;
    logic [47:0] ch_count;
    logic [2:0]  ch_load, ch_latch;

    int nvec = 0, nbad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_host_regs u0 (
        .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
        .wdata (wdata), .rdata (rdata), .live_cnt (live_cnt), .ch_mode (ch_mode),
        .ch_count (ch_count), .ch_load (ch_load), .ch_latch (ch_latch)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    function automatic logic [7:0] ctl(input int ch, input int acc, input int md);
        return 8'((ch << 6) | (acc << 4) | (md << 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++; nvec++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] exp_cnt [NC];
        logic [2:0]  exp_mode [NC];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 mode", 48'(ch_mode), 48'(0));
        chk("R1 count", ch_count, 48'(0));
        chk("R1 strobes", 48'({ch_load, ch_latch}), 48'(0));
        chk("R1 rdata", 48'(rdata), 48'(0));
        for (int c = 0; c < NC; c++) begin exp_cnt[c] = '0; exp_mode[c] = '0; end

        // R3/R4: sweep channels, modes and count values with two-byte access
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < 12; k++) begin
                logic [15:0] v;
                v = 16'((k * 16'h1357) ^ (c * 16'h0101) ^ (k == 11 ? 16'hFFFF : 16'h0));
                exp_mode[c] = 3'(k % 6);
                bwr(2'd3, ctl(c, 3, k % 6));
                for (int o = 0; o < NC; o++)
                    chk("R3 mode", 48'(ch_mode[o*3 +: 3]), 48'(exp_mode[o]));
                bwr(2'(c), v[7:0]);
                chk("R4 no strobe after low byte", 48'(ch_load), 48'(0));
                chk("R4 count held after low byte", 48'(ch_count[c*16 +: 16]), 48'(exp_cnt[c]));
                bwr(2'(c), v[15:8]);
                exp_cnt[c] = v;
                chk("R4 strobe after high byte", 48'(ch_load), 48'(3'b1 << c));
                for (int o = 0; o < NC; o++)
                    chk("R4 count", 48'(ch_count[o*16 +: 16]), 48'(exp_cnt[o]));
                @(negedge clk);
                chk("R4 strobe one cycle", 48'(ch_load), 48'(0));
            end
        end

        // R3: bit 0 ignored
        bwr(2'd3, ctl(2, 3, 3) | 8'h01);
        chk("R3 bit0 ignored", 48'(ch_mode[6 +: 3]), 48'(3));
        exp_mode[2] = 3'd3;
        // R2: channel field 3 does nothing
        bwr(2'd3, 8'hF6);
        chk("R2 sel3 modes", 48'(ch_mode), 48'({exp_mode[2], exp_mode[1], exp_mode[0]}));
        chk("R2 sel3 strobes", 48'({ch_load, ch_latch}), 48'(0));
        bwr(2'd3, 8'hC0);
        chk("R2 sel3 latch ignored", 48'(ch_latch), 48'(0));

        // R6/R7/R8/R9: snapshot behaviour on channel 1
        live_cnt = {16'hA1B2, 16'hBEEF, 16'h5566};
        bwr(2'd3, ctl(1, 3, 2));
        bwr(2'd3, ctl(1, 0, 0));
        chk("R6 latch pulse", 48'(ch_latch), 48'(3'b010));
        chk("R6 mode kept", 48'(ch_mode[3 +: 3]), 48'(2));
        live_cnt[31:16] = 16'h1234;
        bwr(2'd3, ctl(1, 0, 0));
        chk("R8 repeat latch ignored", 48'(ch_latch), 48'(0));
        brd(2'd1, b); chk("R7 low byte", 48'(b), 48'(8'hEF));
        bwr(2'd3, ctl(1, 0, 0));
        chk("R8 latch ignored mid read", 48'(ch_latch), 48'(0));
        brd(2'd1, b); chk("R7 high byte", 48'(b), 48'(8'hBE));
        brd(2'd1, b); chk("R9 live low", 48'(b), 48'(8'h34));
        brd(2'd1, b); chk("R9 live high", 48'(b), 48'(8'h12));
        bwr(2'd3, ctl(1, 0, 0));
        chk("R6 latch after release", 48'(ch_latch), 48'(3'b010));
        live_cnt[31:16] = 16'h7788;
        brd(2'd1, b); chk("R7 new snap low", 48'(b), 48'(8'h34));
        brd(2'd1, b); chk("R7 new snap high", 48'(b), 48'(8'h12));
        brd(2'd0, b); chk("R2 port0 live low", 48'(b), 48'(8'h66));
        brd(2'd2, b); chk("R2 port2 live low", 48'(b), 48'(8'hB2));

        // R10: reprogram resets toggles and drops snapshot
        bwr(2'd3, ctl(2, 3, 0));
        bwr(2'd2, 8'h11);
        bwr(2'd3, ctl(2, 3, 1));
        bwr(2'd2, 8'h22);
        chk("R10 write toggle reset", 48'(ch_load), 48'(0));
        bwr(2'd2, 8'h33);
        chk("R10 count after reprogram", 48'(ch_count[32 +: 16]), 48'(16'h3322));
        bwr(2'd3, ctl(2, 0, 0));
        brd(2'd2, b); chk("R10 snap low", 48'(b), 48'(8'hB2));
        live_cnt[47:32] = 16'hCAFE;
        bwr(2'd3, ctl(2, 3, 1));
        brd(2'd2, b); chk("R10 snap dropped, low first", 48'(b), 48'(8'hFE));
        brd(2'd2, b); chk("R10 live high", 48'(b), 48'(8'hCA));

        // R5: single-byte access types on channel 0
        bwr(2'd3, ctl(0, 1, 4));
        bwr(2'd0, 8'hA5);
        chk("R5 low-only load", 48'({ch_load, ch_count[15:0]}), 48'({3'b001, 16'h00A5}));
        bwr(2'd0, 8'h5A);
        chk("R5 low-only reload", 48'({ch_load, ch_count[15:0]}), 48'({3'b001, 16'h005A}));
        live_cnt[15:0] = 16'h9876;
        brd(2'd0, b); chk("R5 low-only read", 48'(b), 48'(8'h76));
        brd(2'd0, b); chk("R5 low-only read again", 48'(b), 48'(8'h76));
        bwr(2'd3, ctl(0, 2, 5));
        bwr(2'd0, 8'hC3);
        chk("R5 high-only load", 48'({ch_load, ch_count[15:0]}), 48'({3'b001, 16'hC300}));
        brd(2'd0, b); chk("R5 high-only read", 48'(b), 48'(8'h98));
        bwr(2'd3, ctl(0, 0, 0));
        live_cnt[15:0] = 16'h0102;
        brd(2'd0, b); chk("R7 high-only snap", 48'(b), 48'(8'h98));
        brd(2'd0, b); chk("R7 snap released", 48'(b), 48'(8'h01));

        // R11: control read
        brd(2'd3, b); chk("R11 ctl read", 48'(b), 48'(0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule